// File: doc/BRIEF.md
# Windowed Pseudo-Random Address Source

This block supplies command addresses for exercising one memory port. Each request yields one address, drawn either from a pseudo-random sequence or from a linear walk. Every address stays inside a fixed window set by a low bound and a high bound.

Range enforcement costs no comparator on the random path. A linear-feedback shift register supplies raw values. Two constant bit masks, both derived from the bounds at elaboration time, pull each value into the window. One mask clears every bit above the top set bit of the high bound. The other ORs in the low bound, which lifts small values. The result then has its sub-word bits cleared, so it is aligned to the port's data width.

The linear mode starts at the low bound and advances by one data word per request. It returns to the low bound once the next step would pass the high bound.

Top module: `rng_addr_window`

## Requirements
- R1: While rst_n is low, addr reads 0 and addr_vld reads 0.
- R2: addr_vld is 1 in exactly those cycles that follow a clock edge at which req was 1.
- R3: At an edge where req is 0, addr keeps its value.
- R4: For a request with seq_mode=0, addr becomes ((L & ~HM) | LO_ADDR) with its low log2(DATA_BYTES) bits cleared. L is the current shift-register value and HM is the high mask.
- R5: The shift register loads SEED at reset. It advances once per accepted request with seq_mode=0, by a right shift that XORs in the constant TAPS (default 0x80200003) whenever the bit shifted out is 1.
- R6: HM has a 1 in every bit above the most significant set bit of HI_ADDR and a 0 in every other bit. With HI_ADDR=0x3FFF this gives 0xFFFFC000, so no random address has any of those bits set.
- R7: When HI_ADDR is one less than a power of two, every address produced lies between LO_ADDR and HI_ADDR inclusive.
- R8: The first request with seq_mode=1 after reset yields LO_ADDR. Each later request with seq_mode=1 yields the previous linear address plus DATA_BYTES.
- R9: When the previous linear address plus DATA_BYTES would exceed HI_ADDR, the next linear address is LO_ADDR.
- R10: Requests in one mode leave the other mode's state untouched.
- R11: Every address output is a multiple of DATA_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Request for the next address |
| seq_mode | input | 1 | 1 selects the linear walk, 0 the random source |
| addr | output | ADDR_W | Address produced by the last request |
| addr_vld | output | 1 | addr was updated at the last edge |

## Verification
The random source is driven in three patterns: back-to-back requests, requests with gaps, and requests alternating with the linear walk.
- Back-to-back requests compare the register sequence and masking step by step.
- Gapped requests separate stepping per request from stepping per clock.
- Alternation shows whether one mode disturbs the other's state.

A linear run longer than the window crosses the wrap point. This tells an off-by-one bound test apart from a correct return to the low bound.

// File: rtl/rng_addr_window.sv
module rng_addr_window #(
  parameter int ADDR_W = 32,
  parameter int DATA_BYTES = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = 32'h0000_2000,
  parameter logic [ADDR_W-1:0] HI_ADDR = 32'h0000_3FFF,
  parameter logic [ADDR_W-1:0] SEED = 32'h1F35_A6C9,
  parameter logic [ADDR_W-1:0] TAPS = 32'h8020_0003
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              seq_mode,
  output logic [ADDR_W-1:0] addr,
  output logic              addr_vld
);
  localparam int LSB = $clog2(DATA_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN = '1 << LSB;
  localparam logic [ADDR_W:0] STEP = (ADDR_W+1)'(DATA_BYTES);

  function automatic logic [ADDR_W-1:0] high_mask(input logic [ADDR_W-1:0] e);
    logic [ADDR_W-1:0] m;
    m = '1;
    for (int i = 0; i < ADDR_W; i++)
      if (e[i]) m = (i + 1 >= ADDR_W) ? '0 : ('1 << (i + 1));
    return m;
  endfunction

  localparam logic [ADDR_W-1:0] HM = high_mask(HI_ADDR);

  logic [ADDR_W-1:0] lfsr, seq_ptr;
  logic [ADDR_W:0]   seq_sum;
  logic [ADDR_W-1:0] rnd_addr, lfsr_nxt, seq_nxt;

  assign rnd_addr = ((lfsr & ~HM) | LO_ADDR) & ALIGN;
  assign lfsr_nxt = (lfsr >> 1) ^ (lfsr[0] ? TAPS : '0);
  assign seq_sum  = {1'b0, seq_ptr} + STEP;
  assign seq_nxt  = (seq_sum > {1'b0, HI_ADDR}) ? (LO_ADDR & ALIGN) : seq_sum[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr     <= SEED;
      seq_ptr  <= LO_ADDR & ALIGN;
      addr     <= '0;
      addr_vld <= 1'b0;
    end else begin
      addr_vld <= req;
      if (req) begin
        if (seq_mode) begin
          addr    <= seq_ptr;
          seq_ptr <= seq_nxt;
        end else begin
          addr <= rnd_addr;
          lfsr <= lfsr_nxt;
        end
      end
    end
  end
endmodule

module rng_addr_window_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_BYTES = 8,
  parameter logic [ADDR_W-1:0] LO_ADDR = '0,
  parameter logic [ADDR_W-1:0] HI_ADDR = '1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic [ADDR_W-1:0] addr,
  input logic              addr_vld
);
  localparam bit HI_POW2 = ((HI_ADDR + 1'b1) & HI_ADDR) == '0;

  // R2
  vld_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> addr_vld);
  // R2
  no_vld_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && rst_n) |=> !addr_vld);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req && rst_n) |=> $stable(addr));
  // R11
  addr_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld |-> (addr % DATA_BYTES) == 0);
  // R7
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_vld && HI_POW2) |-> (addr >= LO_ADDR && addr <= HI_ADDR));
endmodule

bind rng_addr_window rng_addr_window_chk #(
  .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES), .LO_ADDR(LO_ADDR), .HI_ADDR(HI_ADDR)
) i_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .addr_vld(addr_vld)
);

// File: tb/test_rng_addr_window.sv
module test_rng_addr_window;
  localparam int DB = 8;
  localparam logic [31:0] LO = 32'h0000_2000;
  localparam logic [31:0] HI = 32'h0000_3FFF;
  localparam logic [31:0] SEED = 32'h1F35_A6C9;
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic clk = 0, rst_n = 0, req = 0, seq_mode = 0;
  logic [31:0] addr;
  logic addr_vld;
  int compared = 0, mismatched = 0, cycles = 0;

  rng_addr_window i_rng_addr_window (
    .clk(clk), .rst_n(rst_n), .req(req), .seq_mode(seq_mode),
    .addr(addr), .addr_vld(addr_vld));

  always #5 clk = ~clk;

  logic [31:0] m_lfsr, m_seq, e_addr, hm;
  logic e_vld;
  string tag;

  function automatic logic [31:0] top_mask(input logic [31:0] e);
    int top = -1;
    logic [31:0] m = 0;
    for (int i = 0; i < 32; i++) if (e[i]) top = i;
    for (int i = 31; i > top; i--) m[i] = 1'b1;
    return m;
  endfunction

  initial hm = top_mask(HI);

  task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", r, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_lfsr <= SEED; m_seq <= LO; e_addr <= 0; e_vld <= 0; tag <= "R1";
    end else begin
      e_vld <= req;
      if (!req) tag <= "R3";
      else if (seq_mode) begin
        e_addr <= m_seq;
        m_seq <= (m_seq + DB > HI) ? LO : m_seq + DB;
        tag <= (m_seq + DB > HI) ? "R8 R9 R10" : "R8 R10";
      end else begin
        logic [31:0] v;
        v = ((m_lfsr & ~hm) | LO);
        v = v - (v % DB);
        e_addr <= v;
        m_lfsr <= m_lfsr[0] ? ((m_lfsr >> 1) ^ TAPS) : (m_lfsr >> 1);
        tag <= "R4 R5 R10";
      end
    end
  end

  always @(negedge clk) if (rst_n && cycles > 0) begin
    check(addr_vld === e_vld, "R2", {31'b0, addr_vld}, {31'b0, e_vld});
    check(addr === e_addr, tag, addr, e_addr);
    if (addr_vld) begin
      check(addr >= LO && addr <= HI, "R7", addr, LO);
      check((addr % DB) == 0, "R11", addr, addr - (addr % DB));
      check((addr & 32'hFFFF_C000) == 0, "R6", addr & 32'hFFFF_C000, 0);
    end
  end

  task automatic drive(input bit r, input bit m);
    @(negedge clk);
    req = r; seq_mode = m;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(addr === 0 && addr_vld === 0, "R1", addr, 0);
    rst_n = 1;
    for (int i = 0; i < 400; i++) drive(1, 0);
    for (int i = 0; i < 300; i++) drive(i % 3 != 0, 0);
    for (int i = 0; i < 1100; i++) drive(1, 1);
    for (int i = 0; i < 400; i++) drive(i % 5 != 4, i[0]);
    drive(0, 0);
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1_000_000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule